// File: doc/BRIEF.md
# Prescaled Down-Counting Reload Timer

This block is a general-purpose interval timer. A programmable prescaler divides the reference clock into timer ticks. A 16-bit counter is loaded from a reload register when the timer starts, and it steps down by one on every tick. When the counter is already at zero on a tick, the counter underflows and the block raises a sticky interrupt flag. The timer then either reloads and keeps counting or halts, depending on a configuration bit.

Software can start and stop the timer with single-cycle command strobes. The timer can also start by itself on an end-of-transmit strobe. A gating selector can make counting depend on one of several external gate inputs. The current counter value and a running flag are always visible at the outputs. The running flag means that the timer is armed: in gated mode it stays high while the gate input is low.

Top module: `tick_reload_timer`

## Requirements
- R1: After reset, `cnt_value` is 0, `running` is 0 and `irq` is 0.
- R2: A start request loads `cfg_reload` into the counter on the next clock edge, sets `running`, and restarts the prescaler phase, so the first decrement happens 2·P+1 clock edges after the start edge (P = `cfg_prescale`). A start request is `start_cmd`, or `tx_end` while `cfg_auto_start` is 1.
- R3: While the timer is running and ungated, a tick occurs every 2·P+1 clock cycles, and each tick lowers a non-zero counter by exactly one.
- R4: A tick that finds the counter at zero sets `irq`. With reload R, `irq` first appears (R+1)·(2·P+1) edges after the start edge.
- R5: With `cfg_auto_restart` = 0, the underflow clears `running` and leaves the counter at 0. While the timer is stopped, the counter does not change.
- R6: With `cfg_auto_restart` = 1, the underflow reloads `cfg_reload` and the timer keeps running. Successive underflows are (R+1)·(2·P+1) cycles apart.
- R7: `stop_cmd` clears `running` and freezes the counter on the next edge. It takes priority over a start request in the same cycle.
- R8: `tx_end` starts the timer only when `cfg_auto_start` is 1. Otherwise it has no effect.
- R9: `cfg_gate_sel` = 0 means the timer is ungated. A value k of 1..3 means ticks are counted only while `gate_in[k-1]` is high. While the gate is low, the counter and the prescaler phase hold, and `running` stays 1.
- R10: `irq_clr` clears `irq` on the next edge. An underflow in the same cycle wins, so `irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prescale | input | 12 | Prescaler value P; the tick period is 2·P+1 cycles |
| cfg_reload | input | 16 | Value loaded into the counter on a start or a restart |
| cfg_auto_restart | input | 1 | 1: reload on underflow and keep running |
| cfg_auto_start | input | 1 | 1: `tx_end` acts as a start request |
| cfg_gate_sel | input | 2 | 0 = ungated; k = gate on `gate_in[k-1]` |
| gate_in | input | 3 | External gate levels |
| start_cmd | input | 1 | Single-cycle start strobe |
| stop_cmd | input | 1 | Single-cycle stop strobe |
| tx_end | input | 1 | End-of-transmit strobe |
| irq_clr | input | 1 | Clears the interrupt flag |
| cnt_value | output | 16 | Current counter value |
| running | output | 1 | Timer armed |
| irq | output | 1 | Sticky underflow interrupt flag |

## Verification
The assertions check the per-cycle rules on every cycle:
- a start loads the reload value;
- a stop freezes the counter;
- a tick steps the counter down by exactly one;
- an underflow sets the flag and then either reloads or halts;
- a closed gate or an idle timer holds the counter;
- the flag stays set until it is cleared.

Only the bench scenarios can show the absolute timing. These cover:
- the (R+1)·(2·P+1) distance from start to interrupt across a sweep of prescale and reload values;
- the spacing between repeated underflows in auto-restart mode;
- the wait of a gated timer until its gate opens;
- a `tx_end` strobe being ignored when auto-start is off.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned GATE_SEL_W = 2;
  localparam int unsigned NUM_GATES  = (1 << GATE_SEL_W) - 1;

  typedef enum logic [GATE_SEL_W-1:0] {
    GATE_NONE = 2'd0,
    GATE_ON_0 = 2'd1,
    GATE_ON_1 = 2'd2,
    GATE_ON_2 = 2'd3
  } gate_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  input  logic [PW-1:0] divisor,
  output logic          tick
);
  localparam int unsigned PHW = PW + 1;

  logic [PHW-1:0] phase_q, phase_d;
  logic [PHW-1:0] last_phase;
  logic           phase_en;

  assign last_phase = {divisor, 1'b0};
  assign tick       = advance && (phase_q == last_phase);
  assign phase_en   = restart || advance;

  always_comb begin
    phase_d = phase_q;
    if (restart)   phase_d = '0;
    else if (tick) phase_d = '0;
    else           phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end
endmodule

// File: rtl/tmr_gate.sv
module tmr_gate
  import tmr_pkg::*;
(
  input  logic [GATE_SEL_W-1:0] sel,
  input  logic [NUM_GATES-1:0]  gate_in,
  output logic                  pass
);
  gate_sel_e            mode;
  logic [NUM_GATES-1:0] hit;

  assign mode = gate_sel_e'(sel);

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_hit
    assign hit[g] = (sel == GATE_SEL_W'(g + 1)) && gate_in[g];
  end

  assign pass = (mode == GATE_NONE) || (|hit);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          tick,
  input  logic [CW-1:0] reload,
  input  logic          auto_restart,
  input  logic          irq_clr,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          irq
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          irq_q, irq_d;
  logic          at_zero, underflow, cnt_en;

  assign at_zero   = (cnt_q == '0);
  assign underflow = tick && at_zero && !stop_req && !start_req;
  assign cnt_en    = !stop_req && (start_req || tick);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (stop_req) begin
      run_d = 1'b0;
    end else if (start_req) begin
      cnt_d = reload;
      run_d = 1'b1;
    end else if (tick) begin
      if (!at_zero)          cnt_d = cnt_q - 1'b1;
      else if (auto_restart) cnt_d = reload;
      else                   run_d = 1'b0;
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (underflow)    irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      run_q <= run_d;
      irq_q <= irq_d;
    end
  end

  assign cnt = cnt_q;
  assign run = run_q;
  assign irq = irq_q;
endmodule

// File: rtl/tick_reload_timer.sv
module tick_reload_timer
  import tmr_pkg::*;
#(
  parameter int unsigned PRESC_W = 12,
  parameter int unsigned CNT_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PRESC_W-1:0]    cfg_prescale,
  input  logic [CNT_W-1:0]      cfg_reload,
  input  logic                  cfg_auto_restart,
  input  logic                  cfg_auto_start,
  input  logic [GATE_SEL_W-1:0] cfg_gate_sel,
  input  logic [NUM_GATES-1:0]  gate_in,
  input  logic                  start_cmd,
  input  logic                  stop_cmd,
  input  logic                  tx_end,
  input  logic                  irq_clr,
  output logic [CNT_W-1:0]      cnt_value,
  output logic                  running,
  output logic                  irq
);
  logic start_req;
  logic gate_open;
  logic advance;
  logic tick;

  assign start_req = start_cmd || (cfg_auto_start && tx_end);
  assign advance   = running && gate_open && !stop_cmd && !start_req;

  tmr_gate u_gate (
    .sel     (cfg_gate_sel),
    .gate_in (gate_in),
    .pass    (gate_open)
  );

  tmr_prescaler #(.PW(PRESC_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_req),
    .advance (advance),
    .divisor (cfg_prescale),
    .tick    (tick)
  );

  tmr_core #(.CW(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .stop_req     (stop_cmd),
    .tick         (tick),
    .reload       (cfg_reload),
    .auto_restart (cfg_auto_restart),
    .irq_clr      (irq_clr),
    .cnt          (cnt_value),
    .run          (running),
    .irq          (irq)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned PRESC_W = 12,
  parameter int unsigned CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W-1:0]   cfg_reload,
  input logic               cfg_auto_restart,
  input logic               cfg_auto_start,
  input logic [1:0]         cfg_gate_sel,
  input logic [2:0]         gate_in,
  input logic               start_cmd,
  input logic               stop_cmd,
  input logic               tx_end,
  input logic               irq_clr,
  input logic               tick,
  input logic [CNT_W-1:0]   cnt_value,
  input logic               running,
  input logic               irq
);
  logic start_seen;
  logic quiet;
  logic gate_low;

  assign start_seen = start_cmd || (cfg_auto_start && tx_end);
  assign quiet      = !start_seen && !stop_cmd;
  assign gate_low   = (cfg_gate_sel != 2'd0) && !gate_in[cfg_gate_sel - 2'd1];

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen && !stop_cmd |=> running && (cnt_value == $past(cfg_reload)));

  assert_tick_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && tick && (cnt_value != '0) |=> cnt_value == $past(cnt_value) - 1'b1);

  assert_underflow_sets_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && tick && (cnt_value == '0) |=> irq);

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !start_seen |=> !running && $stable(cnt_value));

  assert_restart_reloads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet && tick && (cnt_value == '0) && cfg_auto_restart
      |=> running && (cnt_value == $past(cfg_reload)));

  assert_stop_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> !running && $stable(cnt_value));

  assert_closed_gate_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    running && quiet && gate_low |=> running && $stable(cnt_value));

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
endmodule

bind tick_reload_timer tmr_checker #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_reload       (cfg_reload),
  .cfg_auto_restart (cfg_auto_restart),
  .cfg_auto_start   (cfg_auto_start),
  .cfg_gate_sel     (cfg_gate_sel),
  .gate_in          (gate_in),
  .start_cmd        (start_cmd),
  .stop_cmd         (stop_cmd),
  .tx_end           (tx_end),
  .irq_clr          (irq_clr),
  .tick             (tick),
  .cnt_value        (cnt_value),
  .running          (running),
  .irq              (irq)
);

// File: tb/sim_tick_reload_timer.sv
`timescale 1ns/1ps
module sim_tick_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_prescale = '0;
  logic [15:0] cfg_reload = '0;
  logic        cfg_auto_restart = 1'b0;
  logic        cfg_auto_start = 1'b0;
  logic [1:0]  cfg_gate_sel = '0;
  logic [2:0]  gate_in = '0;
  logic        start_cmd = 1'b0;
  logic        stop_cmd = 1'b0;
  logic        tx_end = 1'b0;
  logic        irq_clr = 1'b0;
  logic [15:0] cnt_value;
  logic        running;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_reload_timer u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_all();
    @(negedge clk);
    stop_cmd = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0; irq_clr = 1'b0;
    cfg_auto_restart = 1'b0; cfg_auto_start = 1'b0; cfg_gate_sel = '0; gate_in = '0;
  endtask

  // Count edges from the start edge until irq; returns the count.
  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_cmd = 1'b1;
    @(negedge clk); start_cmd = 1'b0;
  endtask

  initial begin
    int n;
    int m;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cnt_value == 0, "R1 cnt", cnt_value, 0);
    check(!running, "R1 running", running, 0);
    check(!irq, "R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 sweep over prescale and reload, auto-restart off
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 5; r++) begin
        idle_all();
        cfg_prescale = 12'(p); cfg_reload = 16'(r);
        @(negedge clk); start_cmd = 1'b1;
        @(negedge clk); start_cmd = 1'b0;
        check(running && cnt_value == 16'(r), "R2 load", cnt_value, r);
        n = 0;
        while (!irq && n < 5000) begin
          @(negedge clk);
          n++;
          if (n == 2*p + 1 && r > 0)
            check(cnt_value == 16'(r - 1), "R3 first decrement", cnt_value, r - 1);
        end
        check(n == (r + 1) * (2*p + 1), "R4 irq time", n, (r + 1) * (2*p + 1));
        check(!running && cnt_value == 0, "R5 halted at zero", cnt_value, 0);
        repeat (4) @(negedge clk);
        check(!running && cnt_value == 0 && irq, "R5 stays idle", cnt_value, 0);
      end
    end

    // R6 auto-restart interval, R10 clear
    idle_all();
    cfg_prescale = 12'd1; cfg_reload = 16'd2; cfg_auto_restart = 1'b1;
    pulse_start();
    wait_irq(n);
    check(n == 9, "R6 first irq", n, 9);
    check(running && cnt_value == 16'd2, "R6 reloaded", cnt_value, 2);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check(!irq, "R10 cleared", irq, 0);
    m = 1;
    while (!irq && m < 5000) begin
      @(negedge clk);
      m++;
    end
    check(m == 9, "R6 restart interval", m, 9);

    // R10 set wins over clear: P=0,R=0 underflows every edge
    idle_all();
    cfg_prescale = 12'd0; cfg_reload = 16'd0; cfg_auto_restart = 1'b1;
    pulse_start();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check(irq, "R10 set wins", irq, 1);

    // R7 stop freezes; stop wins over start
    idle_all();
    cfg_prescale = 12'd2; cfg_reload = 16'd5;
    pulse_start();
    repeat (6) @(negedge clk);
    stop_cmd = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0;
    check(!running && cnt_value == 16'd4, "R7 frozen value", cnt_value, 4);
    repeat (20) @(negedge clk);
    check(cnt_value == 16'd4 && !irq, "R7 stays frozen", cnt_value, 4);
    start_cmd = 1'b1; stop_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0; stop_cmd = 1'b0;
    check(!running && cnt_value == 16'd4, "R7 stop over start", running, 0);

    // R8 auto start
    idle_all();
    cfg_prescale = 12'd3; cfg_reload = 16'd7;
    tx_end = 1'b1;
    @(negedge clk);
    tx_end = 1'b0;
    check(!running && cnt_value == 16'd4, "R8 ignored when off", cnt_value, 4);
    cfg_auto_start = 1'b1;
    tx_end = 1'b1;
    @(negedge clk);
    tx_end = 1'b0;
    check(running && cnt_value == 16'd7, "R8 auto start", cnt_value, 7);

    // R9 gating on each input
    for (int g = 1; g < 4; g++) begin
      idle_all();
      cfg_prescale = 12'd1; cfg_reload = 16'd3; cfg_gate_sel = 2'(g);
      gate_in = 3'b111 & ~(3'b001 << (g - 1));
      pulse_start();
      repeat (20) @(negedge clk);
      check(running && cnt_value == 16'd3 && !irq, "R9 gate closed", cnt_value, 3);
      gate_in[g-1] = 1'b1;
      wait_irq(n);
      check(n == 12, "R9 gate open timing", n, 12);
    end

    idle_all();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule